// File: doc/BRIEF.md
# Handshaked Byte Transfer Engine

This block carries whole packets, one byte at a time, between a host processor and a peripheral controller through a shared 8-bit shift data register. Three active-low lines pace the exchange. The host drives a transfer-in-progress line and an acknowledge line. The block drives a request line back to the host. A direction bit chooses the flow. With shift-out set, each handshake edge appends the shift register to an outbound buffer. With it clear, each edge loads the next inbound byte into the shift register.

When the host releases transfer-in-progress, the block ends the packet. If the outbound buffer holds any bytes, it emits a one-cycle received strobe together with the packet length. While no transfer runs, a toggle of acknowledge is echoed onto the request line, so the host can check that both sides agree. The request line is held low whenever inbound bytes are waiting.

Each byte moved, each echo, each end of packet and each inbound load schedules a shift interrupt pulse. The pulse comes after a programmable delay. It comes at once when the port direction register holds all ones. A new schedule restarts a pending delay.

Top module: `hsk_xfer_engine`

## Requirements
- R1: After reset, req_n is 1, sr_q is 0, pkt_rcv and sr_int are 0, pkt_len is 0, and the port direction register holds 8'hFF.
- R2: With host_tip_n low and shift_out high, a handshake write whose {host_tip_n, host_ack_n} pair differs from the pair of the previous evaluation appends sr_q to the outbound buffer. A write with an unchanged pair appends nothing. Outbound byte k can be read at out_rd_data with out_rd_idx = k.
- R3: The outbound buffer holds DEPTH (16) bytes. Further qualifying edges are dropped, so the packet length never exceeds DEPTH.
- R4: A handshake write with host_tip_n high, after an evaluation with host_tip_n low, ends the packet. If bytes were appended, pkt_rcv is high for exactly one cycle, starting the cycle after the write. pkt_len then shows the count, and the count returns to 0. With no bytes appended there is no strobe.
- R5: With host_tip_n low and shift_out low, a pair-changing write loads the next inbound byte into sr_q in the next cycle. The write that takes the last byte also drives req_n to 1. Once no inbound byte is left, further edges leave sr_q unchanged.
- R6: With host_tip_n high both now and at the previous evaluation, a write that changes host_ack_n copies the new host_ack_n level onto req_n.
- R7: In any idle evaluation that is not an acknowledge echo (a write or an inbound load with host_tip_n high), req_n is driven to 0 while inbound bytes remain unread.
- R8: Each byte moved, echo, end of packet and inbound load schedules one sr_int pulse. With the direction register equal to 8'hFF the pulse is high in the cycle after the event. Otherwise it is high DELAY_CYC cycles after that cycle.
- R9: A schedule that arrives while a delayed pulse is pending restarts the delay, so a single pulse follows DELAY_CYC cycles after the later event.
- R10: An inbound load sets the packet size from in_len, clamped to DEPTH, and restarts reading at byte 0. The next shifted-in byte is entry 0 even if an earlier packet was partly read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pb_wr | input | 1 | Host write of the handshake lines; triggers one evaluation |
| host_tip_n | input | 1 | Transfer-in-progress level written by the host (active low) |
| host_ack_n | input | 1 | Acknowledge level written by the host (active low) |
| dir_wr | input | 1 | Write strobe for the port direction register |
| dir_wdata | input | 8 | New direction register value |
| sr_wr | input | 1 | Host write of the shift register (a same-cycle shift-in wins) |
| sr_wdata | input | 8 | Shift register write data |
| shift_out | input | 1 | Direction bit: 1 host-to-block, 0 block-to-host |
| in_we | input | 1 | Write strobe for one inbound buffer entry |
| in_widx | input | 4 | Inbound buffer entry index |
| in_wdata | input | 8 | Inbound buffer entry data |
| in_load | input | 1 | Start a new inbound packet (ignored in a cycle with pb_wr) |
| in_len | input | 5 | Inbound packet length in bytes |
| out_rd_idx | input | 4 | Outbound buffer read index |
| out_rd_data | output | 8 | Outbound buffer entry at out_rd_idx |
| pkt_rcv | output | 1 | One-cycle received-packet strobe |
| pkt_len | output | 5 | Length of the last received packet |
| req_n | output | 1 | Request line to the host (active low) |
| sr_q | output | 8 | Shift register contents |
| sr_int | output | 1 | One-cycle shift interrupt pulse |

## Verification
The shift register, the request line and the received strobe with its length all settle in the cycle after the write or load that caused them. The interrupt pulse comes in that same cycle when the direction register is all ones. Otherwise it comes DELAY_CYC cycles later. A behavioural model in the bench applies each input at the same clock edge as the design and is compared with every output at each falling edge, so a result that shows up one cycle early or late fails at once. Directed checks also count the cycles from an event to its interrupt pulse, and they read the outbound buffer back after each packet.

// File: rtl/hsk_pkg.sv
package hsk_pkg;

    // Levels of the two host-driven handshake lines, both active low
    typedef struct packed {
        logic tip_n;
        logic ack_n;
    } hs_pair_t;

    typedef enum logic [1:0] {
        MOVE_NONE = 2'd0,
        MOVE_PUSH = 2'd1,
        MOVE_POP  = 2'd2
    } move_e;

    // Actions chosen by one evaluation of the handshake
    typedef struct packed {
        move_e move;
        logic  req_set;
        logic  req_val;
        logic  sched;
        logic  end_pkt;
    } hs_act_t;

    function automatic hs_act_t hs_eval(
        input hs_pair_t now,
        input hs_pair_t prev,
        input logic     shift_out,
        input logic     push_room,
        input logic     pop_avail,
        input logic     pop_last,
        input logic     out_nonempty
    );
        hs_act_t a;
        a = '0;
        a.move = MOVE_NONE;
        if (!now.tip_n) begin
            // busy: a byte moves only on a change of the pair
            if (now != prev) begin
                if (shift_out) begin
                    if (push_room) begin
                        a.move  = MOVE_PUSH;
                        a.sched = 1'b1;
                    end
                end else if (pop_avail) begin
                    a.move  = MOVE_POP;
                    a.sched = 1'b1;
                    if (pop_last) begin
                        a.req_set = 1'b1;
                        a.req_val = 1'b1;
                    end
                end
            end
        end else if (prev.tip_n && (now.ack_n != prev.ack_n)) begin
            // idle echo of the acknowledge level
            a.req_set = 1'b1;
            a.req_val = now.ack_n;
            a.sched   = 1'b1;
        end else begin
            if (!prev.tip_n) begin
                a.sched   = 1'b1;
                a.end_pkt = out_nonempty;
            end
            if (pop_avail) begin
                a.req_set = 1'b1;
                a.req_val = 1'b0;
            end
        end
        return a;
    endfunction

endpackage

// File: rtl/hsk_pkt_buf.sv
module hsk_pkt_buf #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[widx] <= wdata;
        end
    end

    assign rdata = mem[ridx];

endmodule

// File: rtl/hsk_irq_delay.sv
module hsk_irq_delay #(
    parameter int DELAY_CYC = 15000,
    localparam int CNT_W    = $clog2(DELAY_CYC + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic sched,
    input  logic immediate,
    output logic irq
);

    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(DELAY_CYC);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            irq   <= 1'b0;
        end else begin
            irq <= (cnt_q == ONE) || (sched && immediate);
            if (sched && !immediate) begin
                cnt_q <= LOAD_VAL;
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - ONE;
            end
        end
    end

endmodule

// File: rtl/hsk_hs_ctrl.sv
module hsk_hs_ctrl
    import hsk_pkg::*;
#(
    parameter int DEPTH  = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int LEN_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pb_wr,
    input  logic             host_tip_n,
    input  logic             host_ack_n,
    input  logic             sr_wr,
    input  logic [7:0]       sr_wdata,
    input  logic             shift_out,
    input  logic             in_load,
    input  logic [LEN_W-1:0] in_len,
    input  logic [7:0]       pop_data,
    output logic [IDX_W-1:0] pop_idx,
    output logic             push_we,
    output logic [IDX_W-1:0] push_idx,
    output logic             req_n,
    output logic [7:0]       sr_q,
    output logic             pkt_rcv,
    output logic [LEN_W-1:0] pkt_len,
    output logic             sched
);

    localparam logic [LEN_W-1:0] DEPTH_L = LEN_W'(DEPTH);
    localparam logic [LEN_W-1:0] ONE_L   = LEN_W'(1);

    hs_pair_t         prev_q;
    hs_pair_t         now;
    logic [LEN_W-1:0] in_idx_q, in_size_q, out_idx_q;
    logic [LEN_W-1:0] eval_idx, eval_size, len_clamped;
    logic             load_eff, active;
    logic             push_room, pop_avail, pop_last;
    hs_act_t          act;

    assign load_eff    = in_load && !pb_wr;
    assign active      = pb_wr || load_eff;
    assign len_clamped = (in_len > DEPTH_L) ? DEPTH_L : in_len;

    always_comb begin
        now       = pb_wr ? hs_pair_t'{tip_n: host_tip_n, ack_n: host_ack_n} : prev_q;
        eval_idx  = load_eff ? '0 : in_idx_q;
        eval_size = load_eff ? len_clamped : in_size_q;
        push_room = out_idx_q < DEPTH_L;
        pop_avail = eval_idx < eval_size;
        pop_last  = ({1'b0, eval_idx} + {1'b0, ONE_L}) >= {1'b0, eval_size};
        act       = hs_eval(now, prev_q, shift_out, push_room, pop_avail,
                            pop_last, out_idx_q != '0);
    end

    assign pop_idx  = eval_idx[IDX_W-1:0];
    assign push_idx = out_idx_q[IDX_W-1:0];
    assign push_we  = active && (act.move == MOVE_PUSH);
    assign sched    = (active && act.sched) || load_eff;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q    <= '{tip_n: 1'b1, ack_n: 1'b1};
            req_n     <= 1'b1;
            sr_q      <= '0;
            in_idx_q  <= '0;
            in_size_q <= '0;
            out_idx_q <= '0;
            pkt_rcv   <= 1'b0;
            pkt_len   <= '0;
        end else begin
            pkt_rcv <= 1'b0;
            if (sr_wr) begin
                sr_q <= sr_wdata;
            end
            if (load_eff) begin
                in_size_q <= len_clamped;
                in_idx_q  <= '0;
            end
            if (active) begin
                prev_q <= now;
                if (act.move == MOVE_POP) begin
                    sr_q     <= pop_data;
                    in_idx_q <= eval_idx + ONE_L;
                end
                if (act.move == MOVE_PUSH) begin
                    out_idx_q <= out_idx_q + ONE_L;
                end
                if (act.req_set) begin
                    req_n <= act.req_val;
                end
                if (act.end_pkt) begin
                    pkt_rcv   <= 1'b1;
                    pkt_len   <= out_idx_q;
                    out_idx_q <= '0;
                end
            end
        end
    end

endmodule

// File: rtl/hsk_xfer_engine.sv
module hsk_xfer_engine
    import hsk_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int DELAY_CYC = 15000,
    localparam int IDX_W    = $clog2(DEPTH),
    localparam int LEN_W    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pb_wr,
    input  logic             host_tip_n,
    input  logic             host_ack_n,
    input  logic             dir_wr,
    input  logic [7:0]       dir_wdata,
    input  logic             sr_wr,
    input  logic [7:0]       sr_wdata,
    input  logic             shift_out,
    input  logic             in_we,
    input  logic [IDX_W-1:0] in_widx,
    input  logic [7:0]       in_wdata,
    input  logic             in_load,
    input  logic [LEN_W-1:0] in_len,
    input  logic [IDX_W-1:0] out_rd_idx,
    output logic [7:0]       out_rd_data,
    output logic             pkt_rcv,
    output logic [LEN_W-1:0] pkt_len,
    output logic             req_n,
    output logic [7:0]       sr_q,
    output logic             sr_int
);

    logic [7:0]       dir_q;
    logic [IDX_W-1:0] pop_idx, push_idx;
    logic [7:0]       pop_data;
    logic             push_we, sched;

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= 8'hFF;
        end else if (dir_wr) begin
            dir_q <= dir_wdata;
        end
    end

    hsk_hs_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .pb_wr      (pb_wr),
        .host_tip_n (host_tip_n),
        .host_ack_n (host_ack_n),
        .sr_wr      (sr_wr),
        .sr_wdata   (sr_wdata),
        .shift_out  (shift_out),
        .in_load    (in_load),
        .in_len     (in_len),
        .pop_data   (pop_data),
        .pop_idx    (pop_idx),
        .push_we    (push_we),
        .push_idx   (push_idx),
        .req_n      (req_n),
        .sr_q       (sr_q),
        .pkt_rcv    (pkt_rcv),
        .pkt_len    (pkt_len),
        .sched      (sched)
    );

    hsk_pkt_buf #(.DEPTH(DEPTH), .DATA_W(8)) u_in_buf (
        .clk   (clk),
        .we    (in_we),
        .widx  (in_widx),
        .wdata (in_wdata),
        .ridx  (pop_idx),
        .rdata (pop_data)
    );

    hsk_pkt_buf #(.DEPTH(DEPTH), .DATA_W(8)) u_out_buf (
        .clk   (clk),
        .we    (push_we),
        .widx  (push_idx),
        .wdata (sr_q),
        .ridx  (out_rd_idx),
        .rdata (out_rd_data)
    );

    hsk_irq_delay #(.DELAY_CYC(DELAY_CYC)) u_irq (
        .clk       (clk),
        .rst       (rst),
        .sched     (sched),
        .immediate (dir_q == 8'hFF),
        .irq       (sr_int)
    );

endmodule

// File: rtl/hsk_xfer_engine_chk.sv
module hsk_xfer_engine_chk #(
    parameter int DEPTH    = 16,
    localparam int LEN_W   = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             pb_wr,
    input logic             in_load,
    input logic             sr_wr,
    input logic             req_n,
    input logic [7:0]       sr_q,
    input logic             pkt_rcv,
    input logic [LEN_W-1:0] pkt_len,
    input logic             sr_int,
    input logic [7:0]       dir_q
);

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (req_n && !pkt_rcv && !sr_int && sr_q == 8'h00)); // R1

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        pkt_rcv |=> !pkt_rcv); // R4

    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (rst)
        pkt_rcv |-> (pkt_len != '0 && pkt_len <= LEN_W'(DEPTH))); // R3

    AST_END_IRQ_IMMEDIATE: assert property (@(posedge clk) disable iff (rst)
        (pkt_rcv && $past(dir_q) == 8'hFF) |-> sr_int); // R8

    AST_REQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!pb_wr && !in_load) |=> $stable(req_n)); // R6

    AST_SR_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!pb_wr && !in_load && !sr_wr) |=> $stable(sr_q)); // R5

endmodule

bind hsk_xfer_engine hsk_xfer_engine_chk #(.DEPTH(DEPTH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .pb_wr   (pb_wr),
    .in_load (in_load),
    .sr_wr   (sr_wr),
    .req_n   (req_n),
    .sr_q    (sr_q),
    .pkt_rcv (pkt_rcv),
    .pkt_len (pkt_len),
    .sr_int  (sr_int),
    .dir_q   (dir_q)
);

// File: tb/hsk_xfer_engine_test.sv
`timescale 1ns/1ps
module hsk_xfer_engine_test;

    localparam int DEPTH = 16;
    localparam int D     = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pb_wr = 1'b0, host_tip_n = 1'b1, host_ack_n = 1'b1;
    logic       dir_wr = 1'b0;
    logic [7:0] dir_wdata = 8'h00;
    logic       sr_wr = 1'b0;
    logic [7:0] sr_wdata = 8'h00;
    logic       shift_out = 1'b0;
    logic       in_we = 1'b0;
    logic [3:0] in_widx = 4'd0;
    logic [7:0] in_wdata = 8'h00;
    logic       in_load = 1'b0;
    logic [4:0] in_len = 5'd0;
    logic [3:0] out_rd_idx = 4'd0;
    logic [7:0] out_rd_data;
    logic       pkt_rcv;
    logic [4:0] pkt_len;
    logic       req_n;
    logic [7:0] sr_q;
    logic       sr_int;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    hsk_xfer_engine #(.DEPTH(DEPTH), .DELAY_CYC(D)) uut (
        .clk(clk), .rst(rst), .pb_wr(pb_wr), .host_tip_n(host_tip_n),
        .host_ack_n(host_ack_n), .dir_wr(dir_wr), .dir_wdata(dir_wdata),
        .sr_wr(sr_wr), .sr_wdata(sr_wdata), .shift_out(shift_out),
        .in_we(in_we), .in_widx(in_widx), .in_wdata(in_wdata),
        .in_load(in_load), .in_len(in_len), .out_rd_idx(out_rd_idx),
        .out_rd_data(out_rd_data), .pkt_rcv(pkt_rcv), .pkt_len(pkt_len),
        .req_n(req_n), .sr_q(sr_q), .sr_int(sr_int)
    );

    // ---------------- behavioural reference model ----------------
    int   m_ptip, m_pack, m_req, m_sr, m_rcv, m_len, m_int, m_cnt, m_dir;
    int   m_in_idx, m_in_size;
    int   m_inbuf [DEPTH];
    int   m_out [$];
    int   m_last [$];

    always @(posedge clk) begin
        int  old_sr, ntip, nack, imm;
        bit  sched, fire, moved;
        if (rst) begin
            m_ptip = 1; m_pack = 1; m_req = 1; m_sr = 0; m_rcv = 0; m_len = 0;
            m_int = 0; m_cnt = 0; m_dir = 255; m_in_idx = 0; m_in_size = 0;
            m_out.delete();
        end else begin
            sched = 0; fire = 0; moved = 0;
            m_rcv = 0;
            old_sr = m_sr;
            imm = (m_dir == 255);
            if (in_we) m_inbuf[in_widx] = in_wdata;
            if (dir_wr) m_dir = dir_wdata;
            if (sr_wr) m_sr = sr_wdata;
            if (pb_wr || in_load) begin
                if (!pb_wr) begin
                    m_in_size = (in_len > DEPTH) ? DEPTH : in_len;
                    m_in_idx  = 0;
                    sched = 1;
                end
                ntip = pb_wr ? host_tip_n : m_ptip;
                nack = pb_wr ? host_ack_n : m_pack;
                if (ntip == 0) begin
                    if (ntip != m_ptip || nack != m_pack) begin
                        if (shift_out) begin
                            if (m_out.size() < DEPTH) begin
                                m_out.push_back(old_sr);
                                sched = 1;
                            end
                        end else if (m_in_idx < m_in_size) begin
                            m_sr = m_inbuf[m_in_idx];
                            m_in_idx++;
                            sched = 1;
                            if (m_in_idx >= m_in_size) m_req = 1;
                        end
                    end
                end else if (m_ptip == 1 && nack != m_pack) begin
                    m_req = nack;
                    sched = 1;
                end else begin
                    if (m_ptip == 0) begin
                        sched = 1;
                        if (m_out.size() > 0) begin
                            m_rcv = 1;
                            m_len = m_out.size();
                            m_last = m_out;
                            m_out.delete();
                        end
                    end
                    if (m_in_idx < m_in_size) m_req = 0;
                end
                m_ptip = ntip;
                m_pack = nack;
            end
            if (m_cnt == 1) fire = 1;
            if (sched && imm) fire = 1;
            if (sched && !imm) m_cnt = D;
            else if (m_cnt > 0) m_cnt--;
            m_int = fire;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output with the model on every falling edge
    always @(negedge clk) begin
        if (!rst) begin
            chk("R6/R7 req_n vs model",  int'(req_n),   m_req);
            chk("R5 sr_q vs model",      int'(sr_q),    m_sr);
            chk("R4 pkt_rcv vs model",   int'(pkt_rcv), m_rcv);
            chk("R4 pkt_len vs model",   int'(pkt_len), m_len);
            chk("R8 sr_int vs model",    int'(sr_int),  m_int);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic hs(input logic tip, input logic ack);
        host_tip_n = tip; host_ack_n = ack; pb_wr = 1'b1;
        @(negedge clk);
        pb_wr = 1'b0;
    endtask

    task automatic put_sr(input logic [7:0] v);
        sr_wdata = v; sr_wr = 1'b1;
        @(negedge clk);
        sr_wr = 1'b0;
    endtask

    task automatic fill_in(input int idx, input logic [7:0] v);
        in_widx = idx[3:0]; in_wdata = v; in_we = 1'b1;
        @(negedge clk);
        in_we = 1'b0;
    endtask

    task automatic load_in(input int len);
        in_len = len[4:0]; in_load = 1'b1;
        @(negedge clk);
        in_load = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // ---------------- directed sequence ----------------
    initial begin
        int n, pulses;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 req_n after reset", int'(req_n), 1);
        chk("R1 sr_q after reset", int'(sr_q), 0);
        chk("R1 pkt_rcv after reset", int'(pkt_rcv), 0);

        // R2 / R4: host sends three bytes, one repeated write in between
        shift_out = 1'b1;
        put_sr(8'h11); hs(1'b0, 1'b1);
        put_sr(8'h22); hs(1'b0, 1'b0);
        put_sr(8'h99); hs(1'b0, 1'b0);          // unchanged pair: no append
        put_sr(8'h33); hs(1'b0, 1'b1);
        hs(1'b1, 1'b1);
        chk("R4 strobe after end", int'(pkt_rcv), 1);
        chk("R4 length three", int'(pkt_len), 3);
        chk("R8 immediate irq at end", int'(sr_int), 1);
        out_rd_idx = 4'd0; #1 chk("R2 byte 0", int'(out_rd_data), 'h11);
        out_rd_idx = 4'd1; #1 chk("R2 byte 1", int'(out_rd_data), 'h22);
        out_rd_idx = 4'd2; #1 chk("R2 byte 2", int'(out_rd_data), 'h33);
        @(negedge clk);
        chk("R4 strobe lasts one cycle", int'(pkt_rcv), 0);

        // R4: empty transfer gives no strobe
        shift_out = 1'b0;
        hs(1'b0, 1'b1);
        hs(1'b1, 1'b1);
        chk("R4 no strobe when empty", int'(pkt_rcv), 0);

        // R3: seventeen edges, sixteen kept
        shift_out = 1'b1;
        for (int i = 0; i < 17; i++) begin
            put_sr(8'(8'h40 + i));
            hs(1'b0, 1'(i % 2));
        end
        hs(1'b1, 1'b1);
        chk("R3 length capped at depth", int'(pkt_len), DEPTH);
        out_rd_idx = 4'd15; #1 chk("R3 last kept byte", int'(out_rd_data), 'h4F);

        // R6: idle echo of acknowledge
        hs(1'b1, 1'b0);
        chk("R6 req follows ack low", int'(req_n), 0);
        hs(1'b1, 1'b1);
        chk("R6 req follows ack high", int'(req_n), 1);

        // R7 / R5: block sends three bytes
        shift_out = 1'b0;
        fill_in(0, 8'hA1); fill_in(1, 8'hA2); fill_in(2, 8'hA3);
        load_in(3);
        chk("R7 req asserted with data waiting", int'(req_n), 0);
        hs(1'b0, 1'b1);
        chk("R5 first byte", int'(sr_q), 'hA1);
        hs(1'b0, 1'b0);
        chk("R5 second byte", int'(sr_q), 'hA2);
        chk("R5 req still low mid packet", int'(req_n), 0);
        hs(1'b0, 1'b1);
        chk("R5 third byte", int'(sr_q), 'hA3);
        chk("R5 req released on last byte", int'(req_n), 1);
        hs(1'b0, 1'b0);
        chk("R5 no byte past end", int'(sr_q), 'hA3);
        hs(1'b1, 1'b0);
        chk("R4 no strobe after shift-in", int'(pkt_rcv), 0);

        // R10: reload restarts at entry 0
        hs(1'b1, 1'b1);
        fill_in(0, 8'hB1); fill_in(1, 8'hB2);
        load_in(2);
        hs(1'b0, 1'b1);
        chk("R10 first of old packet", int'(sr_q), 'hB1);
        hs(1'b1, 1'b1);
        fill_in(0, 8'hC1); fill_in(1, 8'hC2);
        load_in(20);
        hs(1'b0, 1'b0);
        chk("R10 reload starts at entry 0", int'(sr_q), 'hC1);
        hs(1'b1, 1'b1);
        chk("R7 req low while reload data remains", int'(req_n), 0);

        // R8: delayed interrupt
        dir_wdata = 8'h00; dir_wr = 1'b1; @(negedge clk); dir_wr = 1'b0;
        idle(2);
        hs(1'b1, 1'b0);
        n = 0;
        while (!sr_int && n < 100) begin @(negedge clk); n++; end
        chk("R8 delay in cycles", n, D);

        // R9: retrigger restarts the delay
        idle(3);
        hs(1'b1, 1'b1);
        idle(3);
        hs(1'b1, 1'b0);
        pulses = 0; n = 0;
        for (int i = 0; i < 3 * D; i++) begin
            if (sr_int) begin
                pulses++;
                if (n == 0) n = i;
            end
            @(negedge clk);
        end
        chk("R9 single pulse after retrigger", pulses, 1);
        chk("R9 pulse timed from later event", n, D);

        idle(4);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule